// File: doc/BRIEF.md
# Dual Motion Vector Selector

This block merges the results of two motion-estimation engines that work on the same image block but search opposite halves of the horizontal range. One engine covers negative horizontal displacements and the other covers positive ones. Each engine delivers a byte-serial burst of four bytes: a packed motion vector, a filler byte, then a 16-bit distortion, high byte first. The block keeps whichever candidate has the lower distortion. It moves the engine-relative horizontal field into one common signed range and emits a 9-bit vector after a fixed number of cycles.

The negative-search engine finishes one block period after the positive-search engine. The positive stream is therefore held back by a block-length delay line, so the two bursts for the same image block line up on the internal compare. Two image-edge flags mark a block on the right or left border of the picture. A flag removes the candidate that would point outside the image, and it outranks the distortion comparison. The flags are captured once per block on the start marker and used one block later, together with the candidate they belong to.

Top module: `dual_mv_select`

## Requirements
- R1: Each stream uses a burst phase counted from the cycle in which `blk_start` is high. Phase 0 is the vector byte, phase 1 is a filler byte with no effect on any output, phase 2 is the distortion high byte and phase 3 is the distortion low byte. The negative-stream burst of a block is paired with the positive-stream burst that arrived BLOCK_LEN cycles earlier.
- R2: In the vector byte, bits [7:4] hold a two's-complement horizontal field and bits [3:0] hold the vertical field. The output is `mv_out = {h[4:0], v[3:0]}`. For the positive engine, h is the sign-extended field plus 8 (range 0..15). For the negative engine, h is the sign-extended field minus 8 (range -16..-1). v is passed through unchanged.
- R3: When neither candidate is suppressed, the candidate with the smaller 16-bit distortion is output. Equal distortions select the negative-search candidate.
- R4: A difference in the distortion high bytes decides the outcome, whatever the low bytes hold.
- R5: With the right-edge flag in effect, the positive candidate is suppressed unless its corrected horizontal value is 0 (raw field 4'b1000). This holds regardless of the distortions.
- R6: With the left-edge flag in effect, the negative candidate is suppressed regardless of the distortions.
- R7: When both candidates are suppressed, the positive candidate is output with `mv_ok` = 0. In every other case `mv_ok` = 1.
- R8: The edge flags are sampled only in cycles where `blk_start` is high. They apply to the pair that completes in the following block. Their values in all other cycles are ignored.
- R9: `mv_strobe` is high for exactly one cycle, 4 cycles after the `blk_start` cycle of every paired block (one cycle after the low byte), whatever the outcome. There is no strobe for the first block after reset.
- R10: After reset, `mv_out`, `mv_strobe` and `mv_ok` are 0. `mv_out` and `mv_ok` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | High in phase 0 of each block |
| edge_right | input | 1 | Right image-edge flag, sampled on blk_start |
| edge_left | input | 1 | Left image-edge flag, sampled on blk_start |
| pos_stream | input | 8 | Positive-search engine byte stream |
| neg_stream | input | 8 | Negative-search engine byte stream |
| mv_out | output | 9 | Selected vector {h[4:0], v[3:0]} |
| mv_strobe | output | 1 | One-cycle result strobe |
| mv_ok | output | 1 | Low when both candidates were suppressed |

## Verification
The bench builds the block with BLOCK_LEN = 16 rather than the default of 256. A positive burst therefore pairs with a negative burst after only 16 cycles, and the delay line wraps many times within a few hundred cycles. At that block length, about thirty paired decisions run in a short run. These cover ties, high-byte and low-byte decisions, each edge flag alone and together, and the zero-displacement exception at the right edge. Filler bytes, idle bytes and edge flags outside the start cycle are randomized, so any dependence on them shows up in the selected vector.

// File: rtl/mvsel_pkg.sv
package mvsel_pkg;

    localparam int BYTE_W = 8;
    localparam int HF_W   = 4;
    localparam int VF_W   = 4;
    localparam int HO_W   = HF_W + 1;
    localparam int OUT_W  = HO_W + VF_W;

    localparam logic [2:0] PH_VEC  = 3'd0;
    localparam logic [2:0] PH_MSB  = 3'd2;
    localparam logic [2:0] PH_LSB  = 3'd3;
    localparam logic [2:0] PH_IDLE = 3'd7;

    typedef enum logic [1:0] {
        CMP_EQ       = 2'd0,
        CMP_NEG_LESS = 2'd1,
        CMP_POS_LESS = 2'd2
    } cmp_t;

    typedef struct packed {
        logic [2:0]        phase;
        logic              seen;
        logic              armed;
        logic [BYTE_W-1:0] pvec;
        logic [BYTE_W-1:0] nvec;
        cmp_t              msb_cmp;
        logic [OUT_W-1:0]  out_vec;
        logic              strobe;
        logic              ok;
    } sel_state_t;

    typedef struct packed {
        logic cur_r;
        logic cur_l;
        logic prev_r;
        logic prev_l;
    } edge_state_t;

    // Move an engine-relative horizontal field into the shared signed range.
    function automatic logic [HO_W-1:0] shift_h(input logic [HF_W-1:0] raw, input logic is_neg);
        logic [HO_W-1:0] ext;
        ext = {raw[HF_W-1], raw};
        return is_neg ? ext - HO_W'(8) : ext + HO_W'(8);
    endfunction

    function automatic cmp_t cmp_bytes(input logic [BYTE_W-1:0] n, input logic [BYTE_W-1:0] p);
        if (n < p)      return CMP_NEG_LESS;
        else if (p < n) return CMP_POS_LESS;
        else            return CMP_EQ;
    endfunction

endpackage

// File: rtl/mvsel_delay.sv
module mvsel_delay #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        mem[ptr_q] <= din;
    end

    // The slot about to be overwritten was written DEPTH cycles ago.
    assign dout = mem[ptr_q];

endmodule

// File: rtl/mvsel_edge.sv
module mvsel_edge
    import mvsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic right_in,
    input  logic left_in,
    output logic right_held,
    output logic left_held
);
    edge_state_t es_d, es_q;

    always_comb begin
        es_d = es_q;
        if (sample) begin
            es_d.prev_r = es_q.cur_r;
            es_d.prev_l = es_q.cur_l;
            es_d.cur_r  = right_in;
            es_d.cur_l  = left_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    assign right_held = es_q.prev_r;
    assign left_held  = es_q.prev_l;

endmodule

// File: rtl/mvsel_decide.sv
module mvsel_decide
    import mvsel_pkg::*;
(
    input  logic [BYTE_W-1:0] pvec,
    input  logic [BYTE_W-1:0] nvec,
    input  cmp_t              msb_cmp,
    input  logic [BYTE_W-1:0] lsb_p,
    input  logic [BYTE_W-1:0] lsb_n,
    input  logic              right_held,
    input  logic              left_held,
    output logic [OUT_W-1:0]  pick_vec,
    output logic              pick_ok
);
    logic [HO_W-1:0] pos_h, neg_h;
    logic            pos_ok, neg_ok, neg_wins, take_neg;

    always_comb begin
        pos_h  = shift_h(pvec[BYTE_W-1 -: HF_W], 1'b0);
        neg_h  = shift_h(nvec[BYTE_W-1 -: HF_W], 1'b1);
        pos_ok = !right_held || (pos_h == '0);
        neg_ok = !left_held;

        case (msb_cmp)
            CMP_NEG_LESS: neg_wins = 1'b1;
            CMP_POS_LESS: neg_wins = 1'b0;
            default:      neg_wins = (lsb_n <= lsb_p);
        endcase

        pick_ok = 1'b1;
        if (!pos_ok && !neg_ok) begin
            take_neg = 1'b0;
            pick_ok  = 1'b0;
        end else if (!neg_ok) begin
            take_neg = 1'b0;
        end else if (!pos_ok) begin
            take_neg = 1'b1;
        end else begin
            take_neg = neg_wins;
        end

        pick_vec = take_neg ? {neg_h, nvec[VF_W-1:0]} : {pos_h, pvec[VF_W-1:0]};
    end

endmodule

// File: rtl/dual_mv_select.sv
module dual_mv_select
    import mvsel_pkg::*;
#(
    parameter int BLOCK_LEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start,
    input  logic              edge_right,
    input  logic              edge_left,
    input  logic [BYTE_W-1:0] pos_stream,
    input  logic [BYTE_W-1:0] neg_stream,
    output logic [OUT_W-1:0]  mv_out,
    output logic              mv_strobe,
    output logic              mv_ok
);
    sel_state_t        st_d, st_q;
    logic [2:0]        cur_ph;
    logic [BYTE_W-1:0] pos_late;
    logic              right_held, left_held;
    logic [OUT_W-1:0]  pick_vec;
    logic              pick_ok;

    mvsel_delay #(.DEPTH(BLOCK_LEN), .W(BYTE_W)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pos_stream),
        .dout (pos_late)
    );

    mvsel_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (blk_start),
        .right_in  (edge_right),
        .left_in   (edge_left),
        .right_held(right_held),
        .left_held (left_held)
    );

    mvsel_decide u_dec (
        .pvec      (st_q.pvec),
        .nvec      (st_q.nvec),
        .msb_cmp   (st_q.msb_cmp),
        .lsb_p     (pos_late),
        .lsb_n     (neg_stream),
        .right_held(right_held),
        .left_held (left_held),
        .pick_vec  (pick_vec),
        .pick_ok   (pick_ok)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        cur_ph      = blk_start ? PH_VEC : st_q.phase;
        st_d.phase  = (cur_ph == PH_IDLE) ? PH_IDLE : cur_ph + 3'd1;

        case (cur_ph)
            PH_VEC: begin
                st_d.pvec  = pos_late;
                st_d.nvec  = neg_stream;
                st_d.armed = st_q.seen;
                st_d.seen  = 1'b1;
            end
            PH_MSB: begin
                st_d.msb_cmp = cmp_bytes(neg_stream, pos_late);
            end
            PH_LSB: begin
                if (st_q.armed) begin
                    st_d.out_vec = pick_vec;
                    st_d.ok      = pick_ok;
                    st_d.strobe  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_IDLE;
            st_q.msb_cmp <= CMP_EQ;
        end else begin
            st_q <= st_d;
        end
    end

    assign mv_out    = st_q.out_vec;
    assign mv_strobe = st_q.strobe;
    assign mv_ok     = st_q.ok;

endmodule

// File: rtl/dual_mv_select_chk.sv
module dual_mv_select_chk
    import mvsel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             blk_start,
    input logic [OUT_W-1:0] mv_out,
    input logic             mv_strobe,
    input logic             mv_ok,
    input logic             right_held,
    input logic             left_held
);
    // R9: single-cycle strobe
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_strobe |=> !mv_strobe);

    // R9: fixed latency from the block start
    p_fixed_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_strobe |-> $past(blk_start, 4));

    // R10: outputs hold between strobes
    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_strobe |-> ($stable(mv_out) && $stable(mv_ok)));

    // R6: no accepted negative result while the left flag is held
    p_left_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_strobe && mv_ok && mv_out[OUT_W-1]) |-> !$past(left_held));

    // R5: an accepted positive result at the right edge has zero displacement
    p_right_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_strobe && mv_ok && !mv_out[OUT_W-1] && $past(right_held)) |->
        (mv_out[OUT_W-1 -: HO_W] == '0));

    // R7: a rejected result always carries the positive candidate
    p_reject_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_strobe && !mv_ok) |-> !mv_out[OUT_W-1]);

endmodule

bind dual_mv_select dual_mv_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .mv_out    (mv_out),
    .mv_strobe (mv_strobe),
    .mv_ok     (mv_ok),
    .right_held(right_held),
    .left_held (left_held)
);

// File: tb/dual_mv_select_test.sv
`timescale 1ns/1ps
module dual_mv_select_test;
    localparam int BL = 16;
    localparam int NS = 30;

    typedef struct {
        logic [7:0]  pv;
        logic [15:0] pd;
        logic [7:0]  nv;
        logic [15:0] nd;
        logic        er;
        logic        el;
        string       tag;
    } scen_t;

    typedef struct {
        logic [8:0] vec;
        logic       ok;
        int         due;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start = 1'b0;
    logic       edge_right = 1'b0;
    logic       edge_left = 1'b0;
    logic [7:0] pos_stream = '0;
    logic [7:0] neg_stream = '0;
    logic [8:0] mv_out;
    logic       mv_strobe;
    logic       mv_ok;

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    scen_t sc[NS];
    logic [8:0] last_vec = '0;
    logic       last_ok = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_mv_select #(.BLOCK_LEN(BL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .edge_right(edge_right),
        .edge_left (edge_left),
        .pos_stream(pos_stream),
        .neg_stream(neg_stream),
        .mv_out    (mv_out),
        .mv_strobe (mv_strobe),
        .mv_ok     (mv_ok)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference: full 16-bit compare, edges first (R2, R3, R5, R6, R7).
    function automatic logic [9:0] model(input scen_t s);
        logic [4:0] ph, nh;
        logic       pok, nok, tn, ok;
        ph  = {s.pv[7], s.pv[7:4]} + 5'd8;
        nh  = {s.nv[7], s.nv[7:4]} - 5'd8;
        pok = !s.er || (ph == 5'd0);
        nok = !s.el;
        ok  = 1'b1;
        if (!pok && !nok) begin tn = 1'b0; ok = 1'b0; end
        else if (!nok)    tn = 1'b0;
        else if (!pok)    tn = 1'b1;
        else              tn = (s.nd <= s.pd);
        return tn ? {ok, nh, s.nv[3:0]} : {ok, ph, s.pv[3:0]};
    endfunction

    task automatic set_sc(input int i, input logic [7:0] pv, input logic [15:0] pd,
                          input logic [7:0] nv, input logic [15:0] nd,
                          input logic er, input logic el, input string tag);
        sc[i].pv = pv; sc[i].pd = pd; sc[i].nv = nv; sc[i].nd = nd;
        sc[i].er = er; sc[i].el = el; sc[i].tag = tag;
    endtask

    task automatic drive_block(input logic [7:0] pv, input logic [15:0] pd,
                               input logic er, input logic el,
                               input logic [7:0] nv, input logic [15:0] nd,
                               input bit pair, input scen_t prev);
        exp_t       it;
        logic [9:0] m;
        for (int c = 0; c < BL; c++) begin
            @(negedge clk);
            blk_start = (c == 0);
            if (c == 0) begin
                edge_right = er;
                edge_left  = el;
                if (pair) begin
                    m = model(prev);
                    it.vec = m[8:0];
                    it.ok  = m[9];
                    it.due = cyc + 4;
                    it.tag = prev.tag;
                    expq.push_back(it);
                end
            end else begin
                // R8: flags outside the start cycle are noise
                edge_right = 1'($urandom);
                edge_left  = 1'($urandom);
            end
            case (c)
                0:       begin pos_stream = pv;       neg_stream = nv;       end
                2:       begin pos_stream = pd[15:8]; neg_stream = nd[15:8]; end
                3:       begin pos_stream = pd[7:0];  neg_stream = nd[7:0];  end
                default: begin pos_stream = 8'($urandom); neg_stream = 8'($urandom); end // R1 filler
            endcase
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mv_strobe) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(cyc == e.due, {e.tag, " R9 latency"}, cyc, e.due);
                    check(mv_out == e.vec, {e.tag, " vector"}, int'(mv_out), int'(e.vec));
                    check(mv_ok == e.ok, {e.tag, " R7 ok flag"}, int'(mv_ok), int'(e.ok));
                end
                last_vec <= mv_out;
                last_ok  <= mv_ok;
            end else begin
                check(mv_out == last_vec && mv_ok == last_ok, "R10 hold",
                      int'({mv_ok, mv_out}), int'({last_ok, last_vec}));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_sc(0, 8'h35, 16'h0120, 8'h5A, 16'h0200, 1'b0, 1'b0, "R3 pos smaller R2");
        set_sc(1, 8'h21, 16'h0110, 8'h6C, 16'h010F, 1'b0, 1'b0, "R3 low byte neg");
        set_sc(2, 8'h44, 16'h0444, 8'h33, 16'h0444, 1'b0, 1'b0, "R3 tie neg");
        set_sc(3, 8'h12, 16'h0200, 8'h29, 16'h01FF, 1'b0, 1'b0, "R4 high byte neg");
        set_sc(4, 8'h12, 16'h0100, 8'h29, 16'h0200, 1'b0, 1'b0, "R4 high byte pos");
        set_sc(5, 8'h2A, 16'h0001, 8'h47, 16'hFFFF, 1'b1, 1'b0, "R5 right suppress");
        set_sc(6, 8'h8A, 16'h0001, 8'h47, 16'hFFFF, 1'b1, 1'b0, "R5 right zero kept");
        set_sc(7, 8'h53, 16'hFFFF, 8'h47, 16'h0001, 1'b0, 1'b1, "R6 left suppress");
        set_sc(8, 8'h53, 16'h0005, 8'h47, 16'h0001, 1'b1, 1'b1, "R7 both suppressed");
        set_sc(9, 8'h8B, 16'hFFFF, 8'h47, 16'h0001, 1'b1, 1'b1, "R7 right zero left");
        set_sc(10, 8'h00, 16'h0300, 8'h7F, 16'h0002, 1'b0, 1'b0, "R2 neg minus one");
        set_sc(11, 8'h70, 16'h0300, 8'h83, 16'h0002, 1'b0, 1'b0, "R2 neg minus sixteen");
        set_sc(12, 8'h7E, 16'h0002, 8'h83, 16'h0300, 1'b0, 1'b0, "R2 pos fifteen");
        for (int i = 13; i < NS; i++) begin
            set_sc(i, 8'($urandom), 16'($urandom_range(0, 1023)),
                   8'($urandom), 16'($urandom_range(0, 1023)),
                   1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                   "R3 R5 R6 R8 random");
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mv_out == '0 && !mv_strobe && !mv_ok, "R10 reset",
              int'({mv_strobe, mv_ok, mv_out}), 0);

        for (int k = 0; k <= NS; k++) begin
            scen_t cur, prv;
            if (k < NS) cur = sc[k];
            else begin
                cur.pv = 8'($urandom); cur.pd = 16'($urandom);
                cur.er = 1'($urandom); cur.el = 1'($urandom);
            end
            if (k > 0) prv = sc[k-1];
            else begin
                prv.nv = 8'($urandom); prv.nd = 16'($urandom); prv.tag = "";
            end
            drive_block(cur.pv, cur.pd, cur.er, cur.el, prv.nv, prv.nd, (k > 0), prv);
        end

        repeat (8) @(negedge clk);
        check(expq.size() == 0, "R9 all results delivered", expq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule